// File: doc/BRIEF.md
# Rectangle Blit Loop Sequencer

This block is the control sequencer of a 2D pixel block mover. A rectangle is processed as a number of lines (the outer count), each made of a number of pixels (the inner count). For every inner step the sequencer can issue a source read, a second-pointer add, a destination read, a destination write and a first-pointer add. Which of these steps are used depends on two command enables. Memory steps wait for a bus acknowledge. Pointer adds always take a single cycle.

When the inner count is used up, the sequencer spends one line-end cycle and decrements the outer count. If lines remain, it takes a step cycle, adds a signed per-line X/Y step to the first pointer and starts the next line. In phrase mode each write covers several pixels. The inner count and the X pointer then advance by that pixel count, and the first write of a line may cover fewer pixels when the line starts in the middle of a phrase. An optional window clip turns a destination write into an inhibited write for any pixel that lies outside the window.

The block also resolves two small control fields. The second pointer's Y-add control follows the first pointer's, and the write-data selector applies a fixed precedence.

Top module: `blit_seq`

## Requirements
- R1: After reset busy_o, done_o and all step strobes are low. A start_i pulse seen while busy_o is high has no effect: the counts, enables-driven order and pointers of the running blit are unchanged.
- R2: With both src_en_i and dst_en_i high, each inner step runs src_rd_o, p2_add_o, dst_rd_o, dst write (dst_wr_o or wr_inh_o), then p1_add_o, one state after the other.
- R3: With both enables low, an inner step is a write followed by p1_add_o. With only src_en_i, it is src_rd_o, p2_add_o, write, p1_add_o.
- R4: src_rd_o, dst_rd_o and dst_wr_o each stay asserted until a cycle with mem_ack_i high, and the next step follows in the cycle after that. An inhibited write (wr_inh_o) does not wait for mem_ack_i.
- R5: Each write consumes pixels from the inner count and advances cur_x_o by the same number. That number is 1 outside phrase mode. In phrase mode it is PHRASE_PIX, except for the first write of each line, which covers PHRASE_PIX minus phr_off_i.
- R6: When the signed inner count becomes zero or negative after a write's subtraction, the sequencer spends one line_end_o cycle and decrements the outer count. If the outer count reaches zero there, done_o pulses for one cycle together with the return to idle.
- R7: If lines remain after line end, one line_step_o cycle follows. It adds the signed step_x_i/step_y_i to cur_x_o/cur_y_o, for example (272,144) with step (-10,+1) gives (262,145), and it reloads the inner count latched at start.
- R8: With clip_en_i high, a write step where cur_x_o or cur_y_o has bit 15 set, or cur_x_o >= win_w_i, or cur_y_o >= win_h_i, raises wr_inh_o instead of dst_wr_o. The pointer still advances afterwards.
- R9: p2_yadd_o always equals p1_yadd_i.
- R10: wsel_o gives the write-data source as 2 (adder) when add_sel_i is high, otherwise 1 (pattern) when pat_sel_i is high, otherwise 0 (logic function).
- R11: A start with outer_cnt_i equal to zero issues no step strobes and gives a done_o pulse in the next cycle, with busy_o staying low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches counts and pointers |
| inner_cnt_i | input | CW | Pixels per line |
| outer_cnt_i | input | CW | Number of lines |
| src_en_i | input | 1 | Enable source read per step |
| dst_en_i | input | 1 | Enable destination read per step |
| phrase_i | input | 1 | Phrase mode (multi-pixel writes) |
| phr_off_i | input | OFF_W | Pixel offset of line start within a phrase |
| x_init_i | input | CW | First pointer X at start |
| y_init_i | input | CW | First pointer Y at start |
| step_x_i | input | CW | Signed per-line X step |
| step_y_i | input | CW | Signed per-line Y step |
| clip_en_i | input | 1 | Enable window clip on first pointer |
| win_w_i | input | CW | Clip window width |
| win_h_i | input | CW | Clip window height |
| mem_ack_i | input | 1 | Bus acknowledge for memory steps |
| p1_yadd_i | input | 1 | First pointer Y-add control |
| add_sel_i | input | 1 | Request adder output as write data |
| pat_sel_i | input | 1 | Request pattern as write data |
| busy_o | output | 1 | Blit in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_rd_o | output | 1 | Source read step |
| p2_add_o | output | 1 | Second-pointer add step |
| dst_rd_o | output | 1 | Destination read step |
| dst_wr_o | output | 1 | Destination write step |
| wr_inh_o | output | 1 | Write step suppressed by clip |
| p1_add_o | output | 1 | First-pointer add step |
| line_end_o | output | 1 | Line-end step |
| line_step_o | output | 1 | Per-line pointer step |
| cur_x_o | output | CW | First pointer X |
| cur_y_o | output | CW | First pointer Y |
| p2_yadd_o | output | 1 | Second pointer Y-add control |
| wsel_o | output | 2 | Write-data source select |

## Verification
The sequencer is driven with all four enable combinations. Their step traces are compared against an order computed from the requirements, so a dropped, duplicated or reordered step stands out. Phrase mode is run with a mid-phrase and an aligned start offset, which separates a count that is reduced by one per write from one reduced by the pixels each write covers, and catches a first-write width that is not shortened. Clip runs place pixels past the window edge and at a negative Y, stall runs hold the acknowledge low across each memory step, and a restart pulse mid-blit and a zero line count cover the start handling.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SREAD  = 3'd1,
        ST_P2ADD  = 3'd2,
        ST_DREAD  = 3'd3,
        ST_DWRITE = 3'd4,
        ST_P1ADD  = 3'd5,
        ST_LEND   = 3'd6,
        ST_STEP   = 3'd7
    } seq_st_e;

    localparam logic [1:0] WSEL_LFU = 2'd0;
    localparam logic [1:0] WSEL_PAT = 2'd1;
    localparam logic [1:0] WSEL_ADD = 2'd2;

endpackage

// File: rtl/blit_seq_npix.sv
module blit_seq_npix #(
    parameter int CW         = 16,
    parameter int PHRASE_PIX = 4,
    parameter int OFF_W      = 2
) (
    input  logic             phrase_i,
    input  logic             first_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [CW-1:0]    npix_o
);
    localparam logic [CW-1:0] PP_W  = CW'(PHRASE_PIX);
    localparam bit            POW2  = (PHRASE_PIX > 1) &&
                                      ((PHRASE_PIX & (PHRASE_PIX - 1)) == 0);

    logic [CW-1:0] off_w;
    logic [CW-1:0] first_pix;

    assign off_w = {{(CW-OFF_W){1'b0}}, off_i};

    generate
        if (POW2) begin : g_pow2
            assign first_pix = PP_W - off_w;
        end else begin : g_any
            assign first_pix = (off_w >= PP_W) ? CW'(1) : (PP_W - off_w);
        end
    endgenerate

    always_comb begin
        if (!phrase_i) begin
            npix_o = CW'(1);
        end else if (first_i) begin
            npix_o = first_pix;
        end else begin
            npix_o = PP_W;
        end
    end
endmodule

// File: rtl/blit_seq_clip.sv
module blit_seq_clip #(
    parameter int CW = 16
) (
    input  logic          en_i,
    input  logic [CW-1:0] x_i,
    input  logic [CW-1:0] y_i,
    input  logic [CW-1:0] win_w_i,
    input  logic [CW-1:0] win_h_i,
    output logic          inhibit_o
);
    logic outside;

    always_comb begin
        outside = x_i[CW-1] | y_i[CW-1] | (x_i >= win_w_i) | (y_i >= win_h_i);
        inhibit_o = en_i & outside;
    end
endmodule

// File: rtl/blit_seq.sv
module blit_seq
    import blit_seq_pkg::*;
#(
    parameter int CW         = 16,
    parameter int PHRASE_PIX = 4,
    localparam int OFF_W     = (PHRASE_PIX > 1) ? $clog2(PHRASE_PIX) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CW-1:0]    inner_cnt_i,
    input  logic [CW-1:0]    outer_cnt_i,
    input  logic             src_en_i,
    input  logic             dst_en_i,
    input  logic             phrase_i,
    input  logic [OFF_W-1:0] phr_off_i,
    input  logic [CW-1:0]    x_init_i,
    input  logic [CW-1:0]    y_init_i,
    input  logic [CW-1:0]    step_x_i,
    input  logic [CW-1:0]    step_y_i,
    input  logic             clip_en_i,
    input  logic [CW-1:0]    win_w_i,
    input  logic [CW-1:0]    win_h_i,
    input  logic             mem_ack_i,
    input  logic             p1_yadd_i,
    input  logic             add_sel_i,
    input  logic             pat_sel_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             src_rd_o,
    output logic             p2_add_o,
    output logic             dst_rd_o,
    output logic             dst_wr_o,
    output logic             wr_inh_o,
    output logic             p1_add_o,
    output logic             line_end_o,
    output logic             line_step_o,
    output logic [CW-1:0]    cur_x_o,
    output logic [CW-1:0]    cur_y_o,
    output logic             p2_yadd_o,
    output logic [1:0]       wsel_o
);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] inner;
        logic [CW-1:0] inner_init;
        logic [CW-1:0] outer;
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic          first;
        logic          done;
    } seq_s;

    seq_s seq_d, seq_q;

    logic [CW-1:0] npix;
    logic [CW-1:0] rem;
    logic [CW-1:0] outer_dec;
    logic          inhibit;
    logic          rem_exhausted;
    seq_st_e       entry_st;
    seq_st_e       after_p2_st;

    blit_seq_npix #(
        .CW         (CW),
        .PHRASE_PIX (PHRASE_PIX),
        .OFF_W      (OFF_W)
    ) u_npix (
        .phrase_i (phrase_i),
        .first_i  (seq_q.first),
        .off_i    (phr_off_i),
        .npix_o   (npix)
    );

    blit_seq_clip #(
        .CW (CW)
    ) u_clip (
        .en_i      (clip_en_i),
        .x_i       (seq_q.x),
        .y_i       (seq_q.y),
        .win_w_i   (win_w_i),
        .win_h_i   (win_h_i),
        .inhibit_o (inhibit)
    );

    always_comb begin
        rem           = seq_q.inner - npix;
        rem_exhausted = rem[CW-1] | (rem == '0);
        outer_dec     = seq_q.outer - CW'(1);

        if (src_en_i) begin
            entry_st = ST_SREAD;
        end else if (dst_en_i) begin
            entry_st = ST_DREAD;
        end else begin
            entry_st = ST_DWRITE;
        end
        after_p2_st = dst_en_i ? ST_DREAD : ST_DWRITE;

        seq_d      = seq_q;
        seq_d.done = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (outer_cnt_i == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.inner      = inner_cnt_i;
                        seq_d.inner_init = inner_cnt_i;
                        seq_d.outer      = outer_cnt_i;
                        seq_d.x          = x_init_i;
                        seq_d.y          = y_init_i;
                        seq_d.first      = 1'b1;
                        seq_d.st         = entry_st;
                    end
                end
            end
            ST_SREAD: begin
                if (mem_ack_i) begin
                    seq_d.st = ST_P2ADD;
                end
            end
            ST_P2ADD: begin
                seq_d.st = after_p2_st;
            end
            ST_DREAD: begin
                if (mem_ack_i) begin
                    seq_d.st = ST_DWRITE;
                end
            end
            ST_DWRITE: begin
                if (mem_ack_i || inhibit) begin
                    seq_d.st = ST_P1ADD;
                end
            end
            ST_P1ADD: begin
                seq_d.inner = rem;
                seq_d.x     = seq_q.x + npix;
                seq_d.first = 1'b0;
                seq_d.st    = rem_exhausted ? ST_LEND : entry_st;
            end
            ST_LEND: begin
                seq_d.outer = outer_dec;
                if (outer_dec == '0) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.st = ST_STEP;
                end
            end
            ST_STEP: begin
                seq_d.x     = seq_q.x + step_x_i;
                seq_d.y     = seq_q.y + step_y_i;
                seq_d.inner = seq_q.inner_init;
                seq_d.first = 1'b1;
                seq_d.st    = entry_st;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        busy_o      = (seq_q.st != ST_IDLE);
        done_o      = seq_q.done;
        src_rd_o    = (seq_q.st == ST_SREAD);
        p2_add_o    = (seq_q.st == ST_P2ADD);
        dst_rd_o    = (seq_q.st == ST_DREAD);
        dst_wr_o    = (seq_q.st == ST_DWRITE) && !inhibit;
        wr_inh_o    = (seq_q.st == ST_DWRITE) && inhibit;
        p1_add_o    = (seq_q.st == ST_P1ADD);
        line_end_o  = (seq_q.st == ST_LEND);
        line_step_o = (seq_q.st == ST_STEP);
        cur_x_o     = seq_q.x;
        cur_y_o     = seq_q.y;
        p2_yadd_o   = p1_yadd_i;
        if (add_sel_i) begin
            wsel_o = WSEL_ADD;
        end else if (pat_sel_i) begin
            wsel_o = WSEL_PAT;
        end else begin
            wsel_o = WSEL_LFU;
        end
    end

endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
    parameter int CW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          mem_ack_i,
    input logic [CW-1:0] step_y_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          src_rd_o,
    input logic          p2_add_o,
    input logic          dst_rd_o,
    input logic          dst_wr_o,
    input logic          wr_inh_o,
    input logic          p1_add_o,
    input logic          line_end_o,
    input logic          line_step_o,
    input logic [CW-1:0] cur_y_o
);

    AST_SRC_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_rd_o && !mem_ack_i |=> src_rd_o); // R4

    AST_DRD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_rd_o && !mem_ack_i |=> dst_rd_o); // R4

    AST_WR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dst_wr_o && !mem_ack_i |=> (dst_wr_o || wr_inh_o)); // R4

    AST_SRC_TO_P2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_rd_o && mem_ack_i |=> p2_add_o); // R2

    AST_WR_TO_P1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dst_wr_o && mem_ack_i) || wr_inh_o |=> p1_add_o); // R2

    AST_LEND_AFTER_P1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_end_o |-> $past(p1_add_o)); // R6

    AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o); // R6

    AST_STEP_Y: assert property (@(posedge clk_i) disable iff (!rst_ni)
        line_step_o |=> (cur_y_o == $past(cur_y_o) + $past(step_y_i))); // R7

endmodule

bind blit_seq blit_seq_chk #(.CW(CW)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mem_ack_i   (mem_ack_i),
    .step_y_i    (step_y_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .src_rd_o    (src_rd_o),
    .p2_add_o    (p2_add_o),
    .dst_rd_o    (dst_rd_o),
    .dst_wr_o    (dst_wr_o),
    .wr_inh_o    (wr_inh_o),
    .p1_add_o    (p1_add_o),
    .line_end_o  (line_end_o),
    .line_step_o (line_step_o),
    .cur_y_o     (cur_y_o)
);

// File: tb/blit_seq_tb.sv
`timescale 1ns/1ps
module blit_seq_tb;

    localparam int CW = 16;
    localparam int PP = 4;
    localparam int OW = 2;
    localparam int MAXT = 1024;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] inner_cnt_i = '0;
    logic [CW-1:0] outer_cnt_i = '0;
    logic          src_en_i = 1'b0;
    logic          dst_en_i = 1'b0;
    logic          phrase_i = 1'b0;
    logic [OW-1:0] phr_off_i = '0;
    logic [CW-1:0] x_init_i = '0;
    logic [CW-1:0] y_init_i = '0;
    logic [CW-1:0] step_x_i = '0;
    logic [CW-1:0] step_y_i = '0;
    logic          clip_en_i = 1'b0;
    logic [CW-1:0] win_w_i = '0;
    logic [CW-1:0] win_h_i = '0;
    logic          mem_ack_i = 1'b1;
    logic          p1_yadd_i = 1'b0;
    logic          add_sel_i = 1'b0;
    logic          pat_sel_i = 1'b0;
    logic          busy_o, done_o, src_rd_o, p2_add_o, dst_rd_o, dst_wr_o;
    logic          wr_inh_o, p1_add_o, line_end_o, line_step_o, p2_yadd_o;
    logic [CW-1:0] cur_x_o, cur_y_o;
    logic [1:0]    wsel_o;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    int trc [MAXT];
    int tx  [MAXT];
    int ty  [MAXT];
    int trc_n;
    int expt [MAXT];
    int exp_n;

    always #2.5 clk_i = ~clk_i;

    blit_seq #(.CW(CW), .PHRASE_PIX(PP)) u_dut (.*);

    always @(posedge clk_i) begin
        cycles <= cycles + 1;
        if (cycles >= 100000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // step codes: 1 src read, 2 p2 add, 3 dst read, 4 write, 8 inhibited write,
    // 5 p1 add, 6 line end, 7 line step, 0 none
    function automatic int step_code();
        if (src_rd_o)    return 1;
        if (p2_add_o)    return 2;
        if (dst_rd_o)    return 3;
        if (dst_wr_o)    return 4;
        if (wr_inh_o)    return 8;
        if (p1_add_o)    return 5;
        if (line_end_o)  return 6;
        if (line_step_o) return 7;
        return 0;
    endfunction

    task automatic push_exp(input int c);
        if (exp_n < MAXT) expt[exp_n] = c;
        exp_n = exp_n + 1;
    endtask

    // expected step order built from the requirements
    task automatic build_exp();
        logic [CW-1:0] x, y, cnt, np;
        bit first, inh;
        exp_n = 0;
        x = x_init_i;
        y = y_init_i;
        for (int l = 0; l < int'(outer_cnt_i); l++) begin
            cnt = inner_cnt_i;
            first = 1'b1;
            do begin
                if (src_en_i) begin push_exp(1); push_exp(2); end
                if (dst_en_i) push_exp(3);
                inh = clip_en_i && (x[15] || y[15] || x >= win_w_i || y >= win_h_i);
                push_exp(inh ? 8 : 4);
                push_exp(5);
                np = !phrase_i ? 16'd1 : (first ? 16'(PP - int'(phr_off_i)) : 16'(PP));
                cnt = cnt - np;
                x = x + np;
                first = 1'b0;
            end while (!(cnt[15] || cnt == 0));
            push_exp(6);
            if (l < int'(outer_cnt_i) - 1) begin
                push_exp(7);
                x = x + step_x_i;
                y = y + step_y_i;
            end
        end
    endtask

    // runs one blit with ack held high; inj >= 0 pulses start again at that step
    task automatic run_blit(input int inj);
        logic [CW-1:0] keep_in;
        keep_in = inner_cnt_i;
        build_exp();
        mem_ack_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        trc_n = 0;
        for (int n = 0; n < MAXT; n++) begin
            if (done_o) break;
            trc[trc_n] = step_code();
            tx[trc_n] = int'(cur_x_o);
            ty[trc_n] = int'(cur_y_o);
            trc_n = trc_n + 1;
            if (n == inj) begin
                start_i = 1'b1;
                inner_cnt_i = keep_in + 16'd5;
                outer_cnt_i = outer_cnt_i + 16'd3;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk_i);
        end
        start_i = 1'b0;
    endtask

    task automatic cmp_trace(input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < trc_n && i < exp_n; i++) begin
            if (bad < 0 && trc[i] != expt[i]) bad = i;
        end
        chk(trc_n == exp_n, req, "trace length", trc_n, exp_n);
        if (bad >= 0)
            chk(1'b0, req, $sformatf("step %0d code", bad), trc[bad], expt[bad]);
        else
            chk(1'b1, req, "trace codes", 0, 0);
        chk(done_o && !busy_o, req, "done pulse with idle", int'(done_o), 1);
    endtask

    task automatic set_cfg(input bit s, input bit d, input bit ph, input int off,
                           input int inn, input int out, input int x0, input int y0,
                           input int sx, input int sy, input bit cl, input int w,
                           input int h);
        src_en_i = s; dst_en_i = d; phrase_i = ph; phr_off_i = OW'(off);
        inner_cnt_i = CW'(inn); outer_cnt_i = CW'(out);
        x_init_i = CW'(x0); y_init_i = CW'(y0);
        step_x_i = CW'(sx); step_y_i = CW'(sy);
        clip_en_i = cl; win_w_i = CW'(w); win_h_i = CW'(h);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o, "R1", "busy/done after reset", int'(busy_o), 0);
        chk({src_rd_o, p2_add_o, dst_rd_o, dst_wr_o, wr_inh_o, p1_add_o,
             line_end_o, line_step_o} == '0, "R1", "strobes after reset", 1, 0);
    endtask

    task automatic t_full();
        set_cfg(1, 1, 0, 0, 2, 2, 10, 20, -2, 1, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R2");
        chk(cur_x_o == 16'd12 && cur_y_o == 16'd21, "R6", "final x", int'(cur_x_o), 12);
    endtask

    task automatic t_reduced();
        set_cfg(0, 0, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R3");
        set_cfg(1, 0, 0, 0, 2, 2, 0, 0, 0, 0, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R3");
        set_cfg(0, 1, 0, 0, 2, 1, 0, 0, 0, 0, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R3");
    endtask

    task automatic t_phrase();
        int wr;
        set_cfg(0, 0, 1, 2, 9, 2, 0, 0, -10, 1, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R5");
        wr = 0;
        for (int i = 0; i < trc_n; i++) if (trc[i] == 4) wr++;
        chk(wr == 6, "R5", "phrase writes for 2 lines of 9 px", wr, 6);
        chk(cur_x_o == 16'd10 && cur_y_o == 16'd1, "R5", "x after phrase lines",
            int'(cur_x_o), 10);
        set_cfg(1, 1, 1, 0, 8, 1, 0, 0, 0, 0, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R5");
        chk(cur_x_o == 16'd8, "R5", "x after aligned line", int'(cur_x_o), 8);
    endtask

    task automatic t_step();
        int idx;
        set_cfg(0, 0, 0, 0, 1, 2, 271, 144, -10, 1, 0, 0, 0);
        run_blit(-1);
        cmp_trace("R7");
        idx = -1;
        for (int i = 0; i < trc_n; i++) if (idx < 0 && trc[i] == 7) idx = i;
        chk(idx >= 0 && tx[idx] == 272 && ty[idx] == 144, "R7", "x before step",
            (idx >= 0) ? tx[idx] : -1, 272);
        chk(idx >= 0 && tx[idx+1] == 262 && ty[idx+1] == 145, "R7", "x after step",
            (idx >= 0) ? tx[idx+1] : -1, 262);
        chk(idx >= 0 && ty[idx+1] == 145, "R7", "y after step",
            (idx >= 0) ? ty[idx+1] : -1, 145);
    endtask

    task automatic t_clip();
        set_cfg(0, 0, 0, 0, 4, 1, 2, 5, 0, 0, 1, 4, 100);
        run_blit(-1);
        cmp_trace("R8");
        chk(cur_x_o == 16'd6, "R8", "x advances past inhibited", int'(cur_x_o), 6);
        set_cfg(0, 1, 0, 0, 1, 2, 0, 16'hFFFF, -1, 1, 1, 10, 10);
        run_blit(-1);
        cmp_trace("R8");
    endtask

    task automatic t_stall();
        set_cfg(1, 1, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0);
        mem_ack_i = 1'b0;
        @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        repeat (3) @(negedge clk_i);
        chk(src_rd_o && !p2_add_o, "R4", "src read held", int'(src_rd_o), 1);
        mem_ack_i = 1'b1;
        @(negedge clk_i);
        chk(p2_add_o, "R4", "p2 add after ack", int'(p2_add_o), 1);
        mem_ack_i = 1'b0;
        repeat (3) @(negedge clk_i);
        chk(dst_rd_o, "R4", "dst read held", int'(dst_rd_o), 1);
        mem_ack_i = 1'b1;
        @(negedge clk_i);
        mem_ack_i = 1'b0;
        chk(dst_wr_o, "R4", "write reached", int'(dst_wr_o), 1);
        repeat (2) @(negedge clk_i);
        chk(dst_wr_o && !p1_add_o, "R4", "write held", int'(dst_wr_o), 1);
        mem_ack_i = 1'b1;
        @(negedge clk_i);
        chk(p1_add_o, "R4", "p1 add after write ack", int'(p1_add_o), 1);
        for (int i = 0; i < 20; i++) if (busy_o) @(negedge clk_i);
    endtask

    task automatic t_restart();
        set_cfg(1, 0, 0, 0, 3, 2, 0, 0, 0, 0, 0, 0, 0);
        run_blit(4);
        cmp_trace("R1");
        inner_cnt_i = 16'd3;
        outer_cnt_i = 16'd2;
    endtask

    task automatic t_zero_outer();
        int seen;
        set_cfg(1, 1, 0, 0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk_i);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(done_o && !busy_o, "R11", "done on zero lines", int'(done_o), 1);
        seen = step_code();
        @(negedge clk_i);
        chk(seen == 0 && !busy_o && !done_o, "R11", "no steps, pulse over", seen, 0);
    endtask

    task automatic t_fields();
        p1_yadd_i = 1'b1; #0.1;
        chk(p2_yadd_o == 1'b1, "R9", "p2 yadd follows 1", int'(p2_yadd_o), 1);
        p1_yadd_i = 1'b0; #0.1;
        chk(p2_yadd_o == 1'b0, "R9", "p2 yadd follows 0", int'(p2_yadd_o), 0);
        add_sel_i = 1'b1; pat_sel_i = 1'b1; #0.1;
        chk(wsel_o == 2'd2, "R10", "adder over pattern", int'(wsel_o), 2);
        add_sel_i = 1'b0; #0.1;
        chk(wsel_o == 2'd1, "R10", "pattern over lfu", int'(wsel_o), 1);
        pat_sel_i = 1'b0; #0.1;
        chk(wsel_o == 2'd0, "R10", "lfu default", int'(wsel_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_full();
        t_reduced();
        t_phrase();
        t_step();
        t_clip();
        t_stall();
        t_restart();
        t_zero_outer();
        t_fields();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule